// File: doc/BRIEF.md
# Panel power and mode sequencer

This block keeps the power state and the resolution mode of a small display panel. When either one has to change, it plays the matching command lists out of on-chip tables into a downstream command transmitter. Each command leaves as one word: a parameter count, an opcode and up to two parameter bytes. The word moves under a valid/ready handshake, and the transmitter can flag an error on the handshake that carries it.

Host logic makes a power request by pulsing a strobe with a blank level. It makes a mode request by pulsing another strobe with a horizontal resolution. A static strap selects one of two panel variants. The variants differ in their pass-through and VGA transfer tables and in whether the colour-invert command is sent. A busy flag covers each running sequence. A sticky error flag records a transfer that failed.

Top module: `pnl_pwr_seq`

## Requirements
- R1: After reset the stored level is 4 (powered down) and the current mode is VGA. busy_o, err_o and cmd_valid_o are all low.
- R2: A level of 0 or 1 counts as on and higher levels count as off. An accepted power request starts a sequence only when the on/off status changes. If the status does not change, the new level is stored at once and nothing is sent.
- R3: Power-on sends four groups in this order. First the display-on group: 29; B8 FF F9; 11; B0 16. Then the reset group: opcode 01 followed by three 00 opcodes. Then the full mode setup (R5) for the current mode.
- R4: Power-off sends exactly these four commands: 28; B8 with 80 02; 10; B0 with 00.
- R5: Mode setup sends a pass-through group, then a 27-command configuration group, then a transfer group. The pass-through group is B0 16; BC with 80 (VGA) or 81 (QVGA); E1 00; 36 50 (variant 0 only); 3B with 00 (VGA) or 22 (QVGA). The configuration group starts with B8 FF F9. The transfer group starts with CF 02 (VGA) or D6 02 (QVGA) and ends with 21 then 29. On variant 0 its fourth VGA command is D2 14 00. On variant 1 it is D2 00 1E.
- R6: A resolution of 640 or 480 selects VGA and any other value selects QVGA. A mode request runs mode setup whatever the power state. It sends nothing when the selected mode equals the current mode.
- R7: Variant 0 sends the invert opcode 21 with no parameters. Variant 1 skips it in every group.
- R8: The word is cmd_nparam_o (0 to 2), cmd_op_o, cmd_arg0_o, cmd_arg1_o, with unused arguments 0. It stays stable while cmd_valid_o is high and cmd_ready_i is low.
- R9: A handshake with cmd_err_i high ends the whole sequence and sets err_o. The stored level or mode is then left unchanged. err_o clears on the next accepted request.
- R10: Requests made while busy_o is high are ignored. When both strobes arrive in the same cycle, the power request is taken and the mode request is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| variant_i | input | 1 | Panel variant strap (0 or 1) |
| pwr_req_i | input | 1 | Power request strobe |
| pwr_level_i | input | LVL_W | Requested blank level |
| mode_req_i | input | 1 | Mode request strobe |
| hres_i | input | HRES_W | Requested horizontal resolution |
| cmd_valid_o | output | 1 | Command word valid |
| cmd_ready_i | input | 1 | Transmitter accepts the word |
| cmd_err_i | input | 1 | Transfer error, qualified by the handshake |
| cmd_nparam_o | output | 2 | Parameter count |
| cmd_op_o | output | 8 | Opcode |
| cmd_arg0_o | output | 8 | First parameter |
| cmd_arg1_o | output | 8 | Second parameter |
| busy_o | output | 1 | Sequence in progress |
| err_o | output | 1 | Sticky transfer error |

## Verification
The assertions check four properties on every cycle: the word is held under backpressure, no invert opcode leaves on variant 1, a failed handshake ends the sequence and raises err_o, and stored state does not move during a sequence except at its end. Only the bench scenarios can show the following: the exact content and order of each chained group, the command counts for each variant and mode, the decision whether a power or mode request produces a sequence at all, and the fact that a failed power-off leaves the panel counted as on, so the next request repeats it.

// File: rtl/psq_pkg.sv
package psq_pkg;
  localparam int IDX_W = 5;
  localparam logic [1:0] NP_END = 2'd3;
  localparam logic [7:0] OP_INVERT = 8'h21;

  typedef struct packed {
    logic [1:0] np;
    logic [7:0] op;
    logic [7:0] a0;
    logic [7:0] a1;
  } cmd_t;

  typedef enum logic [2:0] {LS_ON, LS_RST, LS_PT, LS_CFG, LS_XF, LS_OFF} list_e;
  typedef enum logic [1:0] {SQ_ON, SQ_OFF, SQ_MODE} seq_e;

  function automatic cmd_t c0(logic [7:0] op);
    return '{np: 2'd0, op: op, a0: 8'h00, a1: 8'h00};
  endfunction

  function automatic cmd_t c1(logic [7:0] op, logic [7:0] a);
    return '{np: 2'd1, op: op, a0: a, a1: 8'h00};
  endfunction

  function automatic cmd_t c2(logic [7:0] op, logic [7:0] a, logic [7:0] b);
    return '{np: 2'd2, op: op, a0: a, a1: b};
  endfunction

  function automatic cmd_t cend();
    return '{np: NP_END, op: 8'h00, a0: 8'h00, a1: 8'h00};
  endfunction
endpackage

// File: rtl/psq_rom.sv
module psq_rom
  import psq_pkg::*;
(
  input  list_e            sel_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic             vga_i,
  input  logic             var_b_i,
  output cmd_t             cmd_o
);

  function automatic cmd_t on_list(int i);
    case (i)
      0:       return c0(8'h29);
      1:       return c2(8'hB8, 8'hFF, 8'hF9);
      2:       return c0(8'h11);
      3:       return c1(8'hB0, 8'h16);
      default: return cend();
    endcase
  endfunction

  function automatic cmd_t off_list(int i);
    case (i)
      0:       return c0(8'h28);
      1:       return c2(8'hB8, 8'h80, 8'h02);
      2:       return c0(8'h10);
      3:       return c1(8'hB0, 8'h00);
      default: return cend();
    endcase
  endfunction

  function automatic cmd_t rst_list(int i);
    if (i == 0) return c0(8'h01);
    if (i < 4) return c0(8'h00);
    return cend();
  endfunction

  // variant 1 drops the fourth pass-through entry
  function automatic cmd_t pt_list(int i, logic vga, logic vb);
    int k;
    k = (vb && i >= 3) ? i + 1 : i;
    case (k)
      0:       return c1(8'hB0, 8'h16);
      1:       return c1(8'hBC, vga ? 8'h80 : 8'h81);
      2:       return c1(8'hE1, 8'h00);
      3:       return c1(8'h36, 8'h50);
      4:       return c1(8'h3B, vga ? 8'h00 : 8'h22);
      default: return cend();
    endcase
  endfunction

  function automatic cmd_t cfg_list(int i);
    case (i)
      0:       return c2(8'hB8, 8'hFF, 8'hF9);
      1:       return c0(8'h11);
      2:       return c1(8'hBA, 8'h01);
      3:       return c1(8'hBB, 8'h00);
      4:       return c1(8'h3A, 8'h60);
      5:       return c1(8'hBF, 8'h10);
      6:       return c1(8'hB1, 8'h56);
      7:       return c1(8'hB2, 8'h33);
      8:       return c1(8'hB3, 8'h11);
      9:       return c1(8'hB4, 8'h02);
      10:      return c1(8'hB5, 8'h35);
      11:      return c1(8'hB6, 8'h40);
      12:      return c1(8'hB7, 8'h03);
      13:      return c1(8'hBD, 8'h00);
      14:      return c1(8'hBE, 8'h00);
      15:      return c1(8'hC0, 8'h11);
      16:      return c1(8'hC1, 8'h11);
      17:      return c1(8'hC2, 8'h11);
      18:      return c2(8'hC3, 8'h20, 8'h40);
      19:      return c2(8'hC4, 8'h60, 8'hC0);
      20:      return c2(8'hC5, 8'h10, 8'h20);
      21:      return c1(8'hC6, 8'hC0);
      22:      return c2(8'hC7, 8'h33, 8'h43);
      23:      return c1(8'hC8, 8'h44);
      24:      return c1(8'hC9, 8'h33);
      25:      return c1(8'hCA, 8'h00);
      26:      return c2(8'hEC, 8'h01, 8'hF0);
      default: return cend();
    endcase
  endfunction

  function automatic cmd_t xf_vga(int i, logic vb);
    case (i)
      0:       return c1(8'hCF, 8'h02);
      1:       return c2(8'hD0, 8'h08, 8'h04);
      2:       return c1(8'hD1, 8'h01);
      3:       return vb ? c2(8'hD2, 8'h00, 8'h1E) : c2(8'hD2, 8'h14, 8'h00);
      4:       return vb ? c2(8'hD3, 8'h14, 8'h28) : c2(8'hD3, 8'h1A, 8'h0F);
      5:       return vb ? c2(8'hD4, 8'h28, 8'h64) : c2(8'hD4, 8'h1F, 8'hAF);
      6:       return vb ? c1(8'hD5, 8'h28) : c1(8'hD5, 8'h14);
      7:       return c0(OP_INVERT);
      8:       return c0(8'h29);
      default: return cend();
    endcase
  endfunction

  function automatic cmd_t xf_qvga(int i);
    case (i)
      0:       return c1(8'hD6, 8'h02);
      1:       return c2(8'hD7, 8'h08, 8'h04);
      2:       return c1(8'hD8, 8'h01);
      3:       return c2(8'hD9, 8'h00, 8'h08);
      4:       return c2(8'hDE, 8'h05, 8'h0A);
      5:       return c2(8'hDF, 8'h0A, 8'h19);
      6:       return c1(8'hE0, 8'h0A);
      7:       return c0(OP_INVERT);
      8:       return c0(8'h29);
      default: return cend();
    endcase
  endfunction

  always_comb begin
    int i;
    i = int'(idx_i);
    case (sel_i)
      LS_ON:   cmd_o = on_list(i);
      LS_RST:  cmd_o = rst_list(i);
      LS_PT:   cmd_o = pt_list(i, vga_i, var_b_i);
      LS_CFG:  cmd_o = cfg_list(i);
      LS_XF:   cmd_o = vga_i ? xf_vga(i, var_b_i) : xf_qvga(i);
      LS_OFF:  cmd_o = off_list(i);
      default: cmd_o = cend();
    endcase
  end

endmodule

// File: rtl/psq_ctl.sv
module psq_ctl
  import psq_pkg::*;
#(
  parameter int LVL_W   = 3,
  parameter int HRES_W  = 12,
  parameter int ON_MAX  = 1,
  parameter int OFF_LVL = 4,
  parameter int VGA_WA  = 640,
  parameter int VGA_WB  = 480
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pwr_req_i,
  input  logic [LVL_W-1:0]  pwr_level_i,
  input  logic              mode_req_i,
  input  logic [HRES_W-1:0] hres_i,
  input  logic              busy_i,
  input  logic              done_i,
  input  logic              fail_i,
  output logic              start_o,
  output seq_e              kind_o,
  output logic              vga_o,
  output logic              err_o
);

  localparam logic [LVL_W-1:0]  ON_MAX_L  = LVL_W'(ON_MAX);
  localparam logic [LVL_W-1:0]  OFF_LVL_L = LVL_W'(OFF_LVL);
  localparam logic [HRES_W-1:0] WA_L      = HRES_W'(VGA_WA);
  localparam logic [HRES_W-1:0] WB_L      = HRES_W'(VGA_WB);

  logic [LVL_W-1:0] level_q, pend_lvl_q;
  logic             vga_q, pend_vga_q, pend_pwr_q, err_q;
  logic             accept, new_on, cur_on, pwr_edge, req_vga;

  assign accept   = (pwr_req_i || mode_req_i) && !busy_i;
  assign new_on   = pwr_level_i <= ON_MAX_L;
  assign cur_on   = level_q <= ON_MAX_L;
  assign pwr_edge = new_on != cur_on;
  assign req_vga  = (hres_i == WA_L) || (hres_i == WB_L);
  assign err_o    = err_q;

  // power strobe wins over mode strobe
  always_comb begin
    start_o = 1'b0;
    kind_o  = SQ_OFF;
    vga_o   = vga_q;
    if (accept) begin
      if (pwr_req_i) begin
        if (pwr_edge) begin
          start_o = 1'b1;
          kind_o  = new_on ? SQ_ON : SQ_OFF;
        end
      end else if (req_vga != vga_q) begin
        start_o = 1'b1;
        kind_o  = SQ_MODE;
        vga_o   = req_vga;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      level_q    <= OFF_LVL_L;
      pend_lvl_q <= OFF_LVL_L;
      vga_q      <= 1'b1;
      pend_vga_q <= 1'b1;
      pend_pwr_q <= 1'b0;
      err_q      <= 1'b0;
    end else begin
      if (accept) begin
        err_q <= 1'b0;
        if (pwr_req_i) begin
          pend_pwr_q <= 1'b1;
          pend_lvl_q <= pwr_level_i;
          if (!pwr_edge) level_q <= pwr_level_i;
        end else begin
          pend_pwr_q <= 1'b0;
          pend_vga_q <= req_vga;
        end
      end
      if (done_i) begin
        if (pend_pwr_q) level_q <= pend_lvl_q;
        else            vga_q   <= pend_vga_q;
      end
      if (fail_i) err_q <= 1'b1;
    end
  end

  // R9
  err_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_i |=> err_o);

  // R10
  state_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i && !done_i && !fail_i |=> $stable(level_q) && $stable(vga_q));

endmodule

// File: rtl/psq_seq.sv
module psq_seq
  import psq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  seq_e             kind_i,
  input  logic             vga_i,
  input  logic             var_b_i,
  input  cmd_t             rom_i,
  output list_e            sel_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             vga_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             fail_o,
  output logic             cmd_valid_o,
  input  logic             cmd_ready_i,
  input  logic             cmd_err_i,
  output cmd_t             cmd_o
);

  localparam logic [IDX_W-1:0] IDX_ONE  = IDX_W'(1);
  localparam logic [2:0]       STEP_ONE = 3'd1;

  logic             run_q, vga_q;
  seq_e             kind_q;
  logic [2:0]       step_q;
  logic [IDX_W-1:0] idx_q;
  logic             last, is_end, skip;

  // chain of groups per sequence kind
  always_comb begin
    sel_o = LS_OFF;
    last  = 1'b1;
    case (kind_q)
      SQ_ON: begin
        last = step_q >= 3'd4;
        case (step_q)
          3'd0:    sel_o = LS_ON;
          3'd1:    sel_o = LS_RST;
          3'd2:    sel_o = LS_PT;
          3'd3:    sel_o = LS_CFG;
          default: sel_o = LS_XF;
        endcase
      end
      SQ_MODE: begin
        last = step_q >= 3'd2;
        case (step_q)
          3'd0:    sel_o = LS_PT;
          3'd1:    sel_o = LS_CFG;
          default: sel_o = LS_XF;
        endcase
      end
      default: begin
        sel_o = LS_OFF;
        last  = 1'b1;
      end
    endcase
  end

  assign idx_o       = idx_q;
  assign vga_o       = vga_q;
  assign busy_o      = run_q;
  assign is_end      = rom_i.np == NP_END;
  assign skip        = var_b_i && rom_i.np == 2'd0 && rom_i.op == OP_INVERT;
  assign cmd_valid_o = run_q && !is_end && !skip;
  assign cmd_o       = rom_i;
  assign done_o      = run_q && is_end && last;
  assign fail_o      = cmd_valid_o && cmd_ready_i && cmd_err_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      kind_q <= SQ_OFF;
      vga_q  <= 1'b1;
      step_q <= 3'd0;
      idx_q  <= '0;
    end else if (!run_q) begin
      if (start_i) begin
        run_q  <= 1'b1;
        kind_q <= kind_i;
        vga_q  <= vga_i;
        step_q <= 3'd0;
        idx_q  <= '0;
      end
    end else if (is_end) begin
      if (last) run_q <= 1'b0;
      else begin
        step_q <= step_q + STEP_ONE;
        idx_q  <= '0;
      end
    end else if (skip) begin
      idx_q <= idx_q + IDX_ONE;
    end else if (cmd_ready_i) begin
      if (cmd_err_i) run_q <= 1'b0;
      else           idx_q <= idx_q + IDX_ONE;
    end
  end

  // R8
  word_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && !cmd_ready_i |=> cmd_valid_o && $stable(cmd_o));

  // R7
  no_invert_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && var_b_i |-> !(cmd_o.np == 2'd0 && cmd_o.op == OP_INVERT));

  // R9
  fail_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o |=> !busy_o);

  // R8
  no_marker_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |-> busy_o && cmd_o.np != NP_END);

endmodule

// File: rtl/pnl_pwr_seq.sv
module pnl_pwr_seq
  import psq_pkg::*;
#(
  parameter int LVL_W   = 3,
  parameter int HRES_W  = 12,
  parameter int ON_MAX  = 1,
  parameter int OFF_LVL = 4,
  parameter int VGA_WA  = 640,
  parameter int VGA_WB  = 480
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              variant_i,
  input  logic              pwr_req_i,
  input  logic [LVL_W-1:0]  pwr_level_i,
  input  logic              mode_req_i,
  input  logic [HRES_W-1:0] hres_i,
  output logic              cmd_valid_o,
  input  logic              cmd_ready_i,
  input  logic              cmd_err_i,
  output logic [1:0]        cmd_nparam_o,
  output logic [7:0]        cmd_op_o,
  output logic [7:0]        cmd_arg0_o,
  output logic [7:0]        cmd_arg1_o,
  output logic              busy_o,
  output logic              err_o
);

  logic             start, seq_vga, rom_vga, done, fail, busy;
  seq_e             kind;
  list_e            sel;
  logic [IDX_W-1:0] idx;
  cmd_t             rom_cmd, cmd;

  psq_ctl #(
    .LVL_W(LVL_W), .HRES_W(HRES_W), .ON_MAX(ON_MAX),
    .OFF_LVL(OFF_LVL), .VGA_WA(VGA_WA), .VGA_WB(VGA_WB)
  ) u_ctl (
    .clk_i, .rst_ni, .pwr_req_i, .pwr_level_i, .mode_req_i, .hres_i,
    .busy_i(busy), .done_i(done), .fail_i(fail),
    .start_o(start), .kind_o(kind), .vga_o(seq_vga), .err_o
  );

  psq_seq u_seq (
    .clk_i, .rst_ni, .start_i(start), .kind_i(kind), .vga_i(seq_vga),
    .var_b_i(variant_i), .rom_i(rom_cmd), .sel_o(sel), .idx_o(idx),
    .vga_o(rom_vga), .busy_o(busy), .done_o(done), .fail_o(fail),
    .cmd_valid_o, .cmd_ready_i, .cmd_err_i, .cmd_o(cmd)
  );

  psq_rom u_rom (
    .sel_i(sel), .idx_i(idx), .vga_i(rom_vga), .var_b_i(variant_i),
    .cmd_o(rom_cmd)
  );

  assign busy_o       = busy;
  assign cmd_nparam_o = cmd.np;
  assign cmd_op_o     = cmd.op;
  assign cmd_arg0_o   = cmd.a0;
  assign cmd_arg1_o   = cmd.a1;

endmodule

// File: tb/pnl_pwr_seq_bench.sv
module pnl_pwr_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        variant = 1'b0;
  logic        pwr_req = 1'b0;
  logic [2:0]  pwr_lvl = 3'd0;
  logic        mode_req = 1'b0;
  logic [11:0] hres = 12'd0;
  logic        cmd_valid, cmd_ready = 1'b0, cmd_err = 1'b0;
  logic [1:0]  c_np;
  logic [7:0]  c_op, c_a0, c_a1;
  logic        busy, err;

  int nchk = 0, nfail = 0, log_n = 0, err_at = -1, tick = 0;
  logic [25:0] log_q [0:127];

  always #5 clk = ~clk;

  pnl_pwr_seq u_pnl_pwr_seq (
    .clk_i(clk), .rst_ni(rst_n), .variant_i(variant),
    .pwr_req_i(pwr_req), .pwr_level_i(pwr_lvl),
    .mode_req_i(mode_req), .hres_i(hres),
    .cmd_valid_o(cmd_valid), .cmd_ready_i(cmd_ready), .cmd_err_i(cmd_err),
    .cmd_nparam_o(c_np), .cmd_op_o(c_op), .cmd_arg0_o(c_a0), .cmd_arg1_o(c_a1),
    .busy_o(busy), .err_o(err)
  );

  // transmitter model: ready stalls every third cycle
  always @(negedge clk) begin
    tick++;
    cmd_ready = (tick % 3) != 2;
    cmd_err = 1'b0;
    if (cmd_valid && cmd_ready) begin
      cmd_err = (log_n == err_at);
      if (log_n < 128) log_q[log_n] = {c_np, c_op, c_a0, c_a1};
      log_n++;
    end
  end

  task automatic chk(string tag, int act, int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_idle();
    int t = 0;
    while (busy && t < 3000) begin
      @(negedge clk);
      t++;
    end
    if (t >= 3000) chk("watchdog busy", 1, 0);
  endtask

  task automatic do_pwr(input logic [2:0] lvl);
    log_n = 0;
    @(negedge clk);
    pwr_req = 1'b1; pwr_lvl = lvl;
    @(negedge clk);
    pwr_req = 1'b0;
    wait_idle();
  endtask

  task automatic do_mode(input logic [11:0] h);
    log_n = 0;
    @(negedge clk);
    mode_req = 1'b1; hres = h;
    @(negedge clk);
    mode_req = 1'b0;
    wait_idle();
  endtask

  function automatic int ent(int i);
    return int'(log_q[i]);
  endfunction

  function automatic int count_inv();
    int n = 0;
    for (int i = 0; i < log_n && i < 128; i++)
      if (log_q[i] == {2'd0, 8'h21, 16'h0}) n++;
    return n;
  endfunction

  // {is_mode, value, count, first op, last op}
  localparam logic [36:0] VEC [10] = '{
    {1'b0, 12'd0,   8'd49, 8'h29, 8'h29},
    {1'b0, 12'd1,   8'd0,  8'h00, 8'h00},
    {1'b1, 12'd320, 8'd41, 8'hB0, 8'h29},
    {1'b1, 12'd240, 8'd0,  8'h00, 8'h00},
    {1'b1, 12'd480, 8'd41, 8'hB0, 8'h29},
    {1'b0, 12'd4,   8'd4,  8'h28, 8'hB0},
    {1'b0, 12'd2,   8'd0,  8'h00, 8'h00},
    {1'b1, 12'd640, 8'd0,  8'h00, 8'h00},
    {1'b1, 12'd800, 8'd41, 8'hB0, 8'h29},
    {1'b0, 12'd0,   8'd49, 8'h29, 8'h29}
  };

  initial begin
    #2_000_000;
    chk("watchdog run", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 busy", int'(busy), 0);
    chk("R1 err", int'(err), 0);
    chk("R1 valid", int'(cmd_valid), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int v = 0; v < 10; v++) begin
      logic [36:0] e;
      e = VEC[v];
      if (e[36]) do_mode(e[35:24]);
      else       do_pwr(e[26:24]);
      chk($sformatf("R2/R6 count v%0d", v), log_n, int'(e[23:16]));
      if (e[23:16] != 0) begin
        chk($sformatf("R3/R5 first v%0d", v), int'(log_q[0][23:16]), int'(e[15:8]));
        chk($sformatf("R3/R5 last v%0d", v), int'(log_q[log_n-1][23:16]), int'(e[7:0]));
      end
      chk($sformatf("R9 err v%0d", v), int'(err), 0);
      if (v == 0) begin
        chk("R3 on[1]", ent(1), {2'd2, 8'hB8, 8'hFF, 8'hF9});
        chk("R3 on[3]", ent(3), {2'd1, 8'hB0, 8'h16, 8'h00});
        chk("R3 rst[0]", ent(4), {2'd0, 8'h01, 16'h0});
        chk("R3 rst[3]", ent(7), 0);
        chk("R1 vga default", ent(9), {2'd1, 8'hBC, 8'h80, 8'h00});
        chk("R7 invert sent", ent(47), {2'd0, 8'h21, 16'h0});
      end
      if (v == 2) begin
        chk("R5 qvga pt", ent(1), {2'd1, 8'hBC, 8'h81, 8'h00});
        chk("R5 cfg start", ent(5), {2'd2, 8'hB8, 8'hFF, 8'hF9});
        chk("R5 qvga xf", ent(32), {2'd1, 8'hD6, 8'h02, 8'h00});
      end
      if (v == 4) begin
        chk("R5 vga xf", ent(32), {2'd1, 8'hCF, 8'h02, 8'h00});
        chk("R5 var0 d2", ent(35), {2'd2, 8'hD2, 8'h14, 8'h00});
      end
      if (v == 5) begin
        chk("R4 off[0]", ent(0), {2'd0, 8'h28, 16'h0});
        chk("R4 off[1]", ent(1), {2'd2, 8'hB8, 8'h80, 8'h02});
        chk("R4 off[2]", ent(2), {2'd0, 8'h10, 16'h0});
        chk("R4 off[3]", ent(3), {2'd1, 8'hB0, 8'h00, 8'h00});
      end
    end

    // R9 error on second handshake of power-off
    err_at = 1;
    do_pwr(3'd4);
    err_at = -1;
    chk("R9 abort count", log_n, 2);
    chk("R9 err set", int'(err), 1);
    chk("R9 idle", int'(busy), 0);
    do_mode(12'd640);
    chk("R9 err cleared", int'(err), 0);
    chk("R6 mode while on", log_n, 41);
    do_pwr(3'd4);
    chk("R9 level kept", log_n, 4);

    // R10 request while busy is dropped
    do_pwr(3'd0);
    chk("R10 seq", log_n, 49);
    do_pwr(3'd4);
    log_n = 0;
    @(negedge clk);
    pwr_req = 1'b1; pwr_lvl = 3'd0;
    @(negedge clk);
    pwr_req = 1'b0;
    repeat (4) @(negedge clk);
    mode_req = 1'b1; hres = 12'd320;
    @(negedge clk);
    mode_req = 1'b0;
    wait_idle();
    repeat (20) @(negedge clk);
    chk("R10 busy ignore", log_n, 49);
    do_mode(12'd320);
    chk("R10 mode unchanged", log_n, 41);

    // R10 both strobes together: power wins
    do_pwr(3'd4);
    log_n = 0;
    @(negedge clk);
    pwr_req = 1'b1; pwr_lvl = 3'd0; mode_req = 1'b1; hres = 12'd640;
    @(negedge clk);
    pwr_req = 1'b0; mode_req = 1'b0;
    wait_idle();
    chk("R10 priority count", log_n, 49);
    chk("R10 priority mode", ent(9), {2'd1, 8'hBC, 8'h81, 8'h00});

    // variant 1
    rst_n = 1'b0;
    variant = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    do_pwr(3'd1);
    chk("R7 var1 count", log_n, 47);
    chk("R7 var1 no invert", count_inv(), 0);
    chk("R5 var1 pt", ent(11), {2'd1, 8'h3B, 8'h00, 8'h00});
    chk("R5 var1 d2", ent(42), {2'd2, 8'hD2, 8'h00, 8'h1E});
    chk("R3 var1 last", int'(log_q[46][23:16]), 8'h29);
    do_mode(12'd100);
    chk("R6 var1 mode", log_n, 39);
    chk("R7 var1 mode no invert", count_inv(), 0);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule